// File: doc/BRIEF.md
# Triggered ADC Acquisition Controller

This block runs analog-to-digital conversions and keeps the results for a host. A conversion begins on one of three trigger sources: a software strobe, a periodic pacer tick, or a falling edge on an external trigger pin. Two configuration bits pick the source. The block drives a start/done handshake toward the converter. It pushes each returned sample into a 1024-word FIFO, which the host drains through a registered read port.

Status outputs report the FIFO occupancy and a not-empty flag that serves as the data-ready indication. An active-low busy flag is low while a conversion is in flight. Two sticky interrupt flags are available: one for end-of-conversion and one for the FIFO reaching half-full. Each flag has its own enable, and each is cleared by a write-one-to-clear strobe. The trigger source, the way the host drains the data and the interrupt source are all chosen independently.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, `adc_start` and `irq` are 0, `stat_busy_n` is 1, `stat_not_empty` is 0, `fifo_count` is 0 and both interrupt flags are 0.
- R2: With `cfg_ext_sel`=0 and `cfg_pacer_sel`=0, a one-cycle `sw_start` pulse in idle makes `adc_start` high for exactly one cycle, on the clock edge that samples the pulse. `pacer_tick` and `ext_trig` start nothing in this mode.
- R3: With `cfg_ext_sel`=0 and `cfg_pacer_sel`=1, `pacer_tick` starts a conversion and `sw_start` starts nothing.
- R4: With `cfg_ext_sel`=1, `cfg_pacer_sel` is ignored. Only a 1-to-0 transition of `ext_trig` starts a conversion, after a two-flop synchronizer. A rising edge, a steady level, `sw_start` and `pacer_tick` start nothing.
- R5: `stat_busy_n` goes low in the same cycle as `adc_start` and returns high on the edge that samples `adc_done`. Triggers that arrive while busy are ignored.
- R6: Each `adc_done` during a conversion writes `adc_data` into the FIFO at once. `fifo_count` rises by one, and `stat_not_empty` equals (`fifo_count` != 0).
- R7: When `fifo_count` is 1024, further results are dropped. The count stays at 1024 and the stored contents are unchanged.
- R8: A pulse on `rd_en` with the FIFO non-empty presents the oldest sample on `rd_data` at the next edge and decrements the count. A read of an empty FIFO leaves `rd_data` at the last value read and the count at 0.
- R9: `irq_half_flag` sets when the occupancy goes from 511 to 512. It stays set until an `irq_clr_half` pulse.
- R10: `irq_eoc_flag` sets on each accepted `adc_done`. It stays set until an `irq_clr_eoc` pulse.
- R11: `irq` = (`irq_eoc_flag` AND `ien_eoc`) OR (`irq_half_flag` AND `ien_half`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_sel | input | 1 | 1 selects the external trigger pin as source |
| cfg_pacer_sel | input | 1 | When not external: 1 selects the pacer, 0 selects software |
| sw_start | input | 1 | Software start strobe |
| pacer_tick | input | 1 | Periodic pacer tick |
| ext_trig | input | 1 | Asynchronous external trigger, falling-edge active |
| adc_start | output | 1 | One-cycle conversion start to the converter |
| adc_done | input | 1 | Converter result-valid pulse |
| adc_data | input | DATA_W | Converter result |
| rd_en | input | 1 | Host FIFO read strobe |
| rd_data | output | DATA_W | Registered FIFO read data |
| fifo_count | output | CNT_W | FIFO occupancy |
| stat_not_empty | output | 1 | Data-ready flag |
| stat_busy_n | output | 1 | Low while a conversion is in progress |
| ien_eoc | input | 1 | End-of-conversion interrupt enable |
| ien_half | input | 1 | Half-full interrupt enable |
| irq_clr_eoc | input | 1 | Write-one-to-clear of the end-of-conversion flag |
| irq_clr_half | input | 1 | Write-one-to-clear of the half-full flag |
| irq_eoc_flag | output | 1 | Sticky end-of-conversion flag |
| irq_half_flag | output | 1 | Sticky half-full flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume the converter pulses `adc_done` only while a conversion is outstanding, never in the same cycle as `adc_start`. They also assume the host does not pulse `rd_en` and a clear strobe in ways that rely on a particular order within one edge. The bench's converter model answers each start with a single done pulse a few cycles later. All strobes are driven as single-cycle pulses on the falling clock edge. FIFO reads are issued only while no conversion is running, so the bench's occupancy model and the design's count move in step.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_RUN  = 1'b1
    } conv_state_e;

    typedef struct packed {
        conv_state_e state;
        logic        start;
    } conv_regs_t;

    typedef struct packed {
        logic eoc;
        logic half;
    } irq_regs_t;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic pacer_sel,
    input  logic sw_start,
    input  logic pacer_tick,
    input  logic ext_trig,
    output logic trig
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } trig_regs_t;

    trig_regs_t r_q, r_d;
    logic ext_fall;

    always_comb begin
        r_d = r_q;
        if (SYNC_STAGES > 1) begin
            r_d.sync = {r_q.sync[SYNC_STAGES-2:0], ext_trig};
        end else begin
            r_d.sync = ext_trig;
        end
        r_d.prev = r_q.sync[SYNC_STAGES-1];
        ext_fall = r_q.prev & ~r_q.sync[SYNC_STAGES-1];
        if (ext_sel) begin
            trig = ext_fall;
        end else if (pacer_sel) begin
            trig = pacer_tick;
        end else begin
            trig = sw_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sync: '1, prev: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              half_evt
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_PRE = CNT_W'(DEPTH / 2 - 1);

    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdat;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;

    always_comb begin
        r_d   = r_q;
        wr_ok = wr_en && (r_q.cnt != FULL_CNT);
        rd_ok = rd_en && (r_q.cnt != '0);
        if (wr_ok) begin
            r_d.wptr = r_q.wptr + 1'b1;
        end
        if (rd_ok) begin
            r_d.rptr = r_q.rptr + 1'b1;
            r_d.rdat = mem[r_q.rptr];
        end
        case ({wr_ok, rd_ok})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
        half_evt = wr_ok && !rd_ok && (r_q.cnt == HALF_PRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[r_q.wptr] <= wr_data;
        end
    end

    assign rd_data = r_q.rdat;
    assign count   = r_q.cnt;
endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit
    import adc_acq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_evt,
    input  logic half_evt,
    input  logic clr_eoc,
    input  logic clr_half,
    input  logic en_eoc,
    input  logic en_half,
    output logic eoc_flag,
    output logic half_flag,
    output logic irq
);
    irq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr_eoc) r_d.eoc = 1'b0;
        if (eoc_evt) r_d.eoc = 1'b1;
        if (clr_half) r_d.half = 1'b0;
        if (half_evt) r_d.half = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign eoc_flag  = r_q.eoc;
    assign half_flag = r_q.half;
    assign irq       = (r_q.eoc & en_eoc) | (r_q.half & en_half);
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
    import adc_acq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext_sel,
    input  logic              cfg_pacer_sel,
    input  logic              sw_start,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              stat_not_empty,
    output logic              stat_busy_n,
    input  logic              ien_eoc,
    input  logic              ien_half,
    input  logic              irq_clr_eoc,
    input  logic              irq_clr_half,
    output logic              irq_eoc_flag,
    output logic              irq_half_flag,
    output logic              irq
);
    conv_regs_t r_q, r_d;
    logic trig, conv_done, half_evt;

    adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
        .clk(clk), .rst_n(rst_n), .ext_sel(cfg_ext_sel), .pacer_sel(cfg_pacer_sel),
        .sw_start(sw_start), .pacer_tick(pacer_tick), .ext_trig(ext_trig), .trig(trig)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        conv_done = 1'b0;
        case (r_q.state)
            CONV_IDLE: begin
                if (trig) begin
                    r_d.state = CONV_RUN;
                    r_d.start = 1'b1;
                end
            end
            CONV_RUN: begin
                if (adc_done) begin
                    conv_done = 1'b1;
                    r_d.state = CONV_IDLE;
                end
            end
            default: r_d.state = CONV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: CONV_IDLE, start: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    adc_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(conv_done), .wr_data(adc_data),
        .rd_en(rd_en), .rd_data(rd_data), .count(fifo_count), .half_evt(half_evt)
    );

    adc_irq_unit irq_i (
        .clk(clk), .rst_n(rst_n), .eoc_evt(conv_done), .half_evt(half_evt),
        .clr_eoc(irq_clr_eoc), .clr_half(irq_clr_half), .en_eoc(ien_eoc),
        .en_half(ien_half), .eoc_flag(irq_eoc_flag), .half_flag(irq_half_flag), .irq(irq)
    );

    assign adc_start      = r_q.start;
    assign stat_busy_n    = (r_q.state == CONV_IDLE);
    assign stat_not_empty = (fifo_count != '0);
endmodule

// File: rtl/adc_acq_chk.sv
module adc_acq_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_start,
    input logic              adc_done,
    input logic              stat_busy_n,
    input logic              stat_not_empty,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_eoc_flag,
    input logic              irq_clr_eoc,
    input logic              irq_half_flag,
    input logic              irq_clr_half
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) adc_start |=> !adc_start); // R2
    AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n) adc_start |-> !stat_busy_n); // R5
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n) (adc_done && !stat_busy_n && !adc_start) |=> stat_busy_n); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_count <= CNT_W'(DEPTH)); // R7
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fifo_count == CNT_W'(DEPTH) && !rd_en) |=> fifo_count == CNT_W'(DEPTH)); // R7
    AST_READY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) stat_not_empty == (fifo_count != '0)); // R6
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && fifo_count == '0) |=> $stable(rd_data)); // R8
    AST_EOC_SET: assert property (@(posedge clk) disable iff (!rst_n) (adc_done && !stat_busy_n && !adc_start) |=> irq_eoc_flag); // R10
    AST_EOC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_eoc_flag && !irq_clr_eoc) |=> irq_eoc_flag); // R10
    AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_half_flag && !irq_clr_half) |=> irq_half_flag); // R9
endmodule

bind adc_acq_ctrl adc_acq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_done(adc_done),
    .stat_busy_n(stat_busy_n), .stat_not_empty(stat_not_empty), .fifo_count(fifo_count),
    .rd_en(rd_en), .rd_data(rd_data), .irq_eoc_flag(irq_eoc_flag), .irq_clr_eoc(irq_clr_eoc),
    .irq_half_flag(irq_half_flag), .irq_clr_half(irq_clr_half)
);

// File: tb/adc_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_acq_ctrl_tb_top;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1024;
    localparam int CNT_W  = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ext_sel = 1'b0, cfg_pacer_sel = 1'b0;
    logic sw_start = 1'b0, pacer_tick = 1'b0, ext_trig = 1'b1;
    logic adc_start, adc_done = 1'b0;
    logic [DATA_W-1:0] adc_data = '0;
    logic rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0] fifo_count;
    logic stat_not_empty, stat_busy_n;
    logic ien_eoc = 1'b0, ien_half = 1'b0, irq_clr_eoc = 1'b0, irq_clr_half = 1'b0;
    logic irq_eoc_flag, irq_half_flag, irq;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int model_cnt = 0;
    logic [DATA_W-1:0] next_val = 16'h1000;
    logic [DATA_W-1:0] last_rd = '0;
    logic [DATA_W-1:0] exp_q [$];
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    adc_acq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ext_sel(cfg_ext_sel), .cfg_pacer_sel(cfg_pacer_sel),
        .sw_start(sw_start), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
        .stat_not_empty(stat_not_empty), .stat_busy_n(stat_busy_n),
        .ien_eoc(ien_eoc), .ien_half(ien_half), .irq_clr_eoc(irq_clr_eoc),
        .irq_clr_half(irq_clr_half), .irq_eoc_flag(irq_eoc_flag),
        .irq_half_flag(irq_half_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter model and scoreboard driver: each start yields one result.
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                n_start++;
                repeat (3) @(negedge clk);
                adc_data = next_val;
                adc_done = 1'b1;
                if (model_cnt < DEPTH) begin
                    exp_q.push_back(next_val);
                    model_cnt++;
                end
                next_val = next_val + 16'd1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic pulse_sw();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic do_conv();
        pulse_sw();
        while (!stat_busy_n) @(negedge clk);
    endtask

    // Monitor side: pop the oldest expected item and compare with the read port.
    task automatic read_one(input string tag);
        logic [DATA_W-1:0] e;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        if (model_cnt > 0) begin
            e = exp_q.pop_front();
            model_cnt--;
            last_rd = e;
            check(rd_data == e, tag, 32'(rd_data), 32'(e));
        end else begin
            check(rd_data == last_rd, tag, 32'(rd_data), 32'(last_rd));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(adc_start == 0 && irq == 0 && stat_busy_n == 1 && stat_not_empty == 0 &&
              fifo_count == 0 && irq_eoc_flag == 0 && irq_half_flag == 0, "R1 reset state",
              {adc_start, irq, stat_busy_n, stat_not_empty, irq_eoc_flag, irq_half_flag}, 32'h08);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 software start: adc_start visible at the negedge right after the strobe edge
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        check(adc_start == 1, "R2 start pulse", 32'(adc_start), 1);
        check(stat_busy_n == 0, "R5 busy low with start", 32'(stat_busy_n), 0);
        // R5 trigger while busy ignored
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        while (!stat_busy_n) @(negedge clk);
        repeat (3) @(negedge clk);
        check(n_start == 1, "R5 busy trigger ignored", 32'(n_start), 1);
        check(fifo_count == 1 && stat_not_empty, "R6 result stored", 32'(fifo_count), 1);
        check(irq_eoc_flag == 1 && irq == 0, "R10 eoc flag set, R11 masked",
              {irq_eoc_flag, irq}, 32'h2);
        ien_eoc = 1'b1;
        @(negedge clk);
        check(irq == 1, "R11 eoc enabled", 32'(irq), 1);
        irq_clr_eoc = 1'b1; @(negedge clk); irq_clr_eoc = 1'b0;
        check(irq_eoc_flag == 0 && irq == 0, "R10 eoc clear", {irq_eoc_flag, irq}, 0);
        ien_eoc = 1'b0;

        // R2 pacer/ext ignored in software mode
        base = n_start;
        @(negedge clk); pacer_tick = 1'b1; ext_trig = 1'b0;
        @(negedge clk); pacer_tick = 1'b0;
        repeat (8) @(negedge clk);
        ext_trig = 1'b1;
        repeat (8) @(negedge clk);
        check(n_start == base, "R2 other sources ignored", 32'(n_start), 32'(base));

        // R3 pacer mode
        cfg_pacer_sel = 1'b1;
        pulse_sw();
        repeat (8) @(negedge clk);
        check(n_start == base, "R3 sw ignored in pacer mode", 32'(n_start), 32'(base));
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        while (!stat_busy_n) @(negedge clk);
        check(n_start == base + 1, "R3 pacer starts", 32'(n_start), 32'(base + 1));

        // R4 external mode, pacer_sel left at 1 (ignored)
        cfg_ext_sel = 1'b1;
        repeat (4) @(negedge clk);
        pulse_sw();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        repeat (8) @(negedge clk);
        check(n_start == base + 1, "R4 sw/pacer ignored in ext mode", 32'(n_start), 32'(base + 1));
        ext_trig = 1'b0;
        repeat (12) @(negedge clk);
        check(n_start == base + 2, "R4 falling edge starts", 32'(n_start), 32'(base + 2));
        repeat (10) @(negedge clk);
        check(n_start == base + 2, "R4 low level no restart", 32'(n_start), 32'(base + 2));
        ext_trig = 1'b1;
        repeat (12) @(negedge clk);
        check(n_start == base + 2, "R4 rising edge ignored", 32'(n_start), 32'(base + 2));
        cfg_ext_sel = 1'b0; cfg_pacer_sel = 1'b0;

        // R8 drain what is stored, in order
        while (model_cnt > 0) read_one("R8 fifo order");
        check(fifo_count == 0 && !stat_not_empty, "R8 drained", 32'(fifo_count), 0);

        // R9 half-full threshold
        for (int i = 0; i < DEPTH / 2 - 1; i++) do_conv();
        check(irq_half_flag == 0 && fifo_count == CNT_W'(DEPTH / 2 - 1), "R9 below half",
              32'(fifo_count), 32'(DEPTH / 2 - 1));
        do_conv();
        check(irq_half_flag == 1, "R9 half flag set at 512", 32'(irq_half_flag), 1);
        ien_half = 1'b1; @(negedge clk);
        check(irq == 1, "R11 half enabled", 32'(irq), 1);
        repeat (5) @(negedge clk);
        check(irq_half_flag == 1, "R9 half sticky", 32'(irq_half_flag), 1);
        irq_clr_half = 1'b1; @(negedge clk); irq_clr_half = 1'b0;
        check(irq_half_flag == 0, "R9 half cleared", 32'(irq_half_flag), 0);
        irq_clr_eoc = 1'b1; @(negedge clk); irq_clr_eoc = 1'b0;
        check(irq == 0, "R11 no flags no irq", 32'(irq), 0);
        do_conv();
        check(irq_half_flag == 0, "R9 no re-set above half", 32'(irq_half_flag), 0);

        // R7 fill and overflow
        while (model_cnt < DEPTH) do_conv();
        check(fifo_count == CNT_W'(DEPTH), "R7 full", 32'(fifo_count), DEPTH);
        do_conv();
        do_conv();
        check(fifo_count == CNT_W'(DEPTH), "R7 count holds when full", 32'(fifo_count), DEPTH);
        while (model_cnt > 0) read_one("R7 contents kept");
        check(fifo_count == 0, "R8 empty after drain", 32'(fifo_count), 0);

        // R8 empty read
        read_one("R8 empty read keeps data");
        check(fifo_count == 0, "R8 empty read count", 32'(fifo_count), 0);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule